// File: doc/BRIEF.md
# Racing Dual-Engine Unsigned Divider

This block divides one unsigned integer by another by starting two sequential division engines at the same moment and keeping whichever answer arrives first. The first engine subtracts the divisor over and over until the remainder drops below it. Its run time therefore follows the size of the quotient: it is very quick for small quotients and very slow for large ones. The second engine is a non-restoring divider. It always spends one step on each quotient bit and then makes one correction step.

A controller latches the operands and launches both engines together. It watches the two completion flags, steers the output multiplexer toward the first finisher and registers that result. It then pulses done and clears both engines, so the slower one stops. Because of this race, small quotients come back quickly, while the worst case is bounded by the fixed-latency engine. A zero divisor skips both engines and returns a flagged result straight away. The interface is a plain start/busy/done handshake with no queueing.

Top module: `race_div`

## Requirements
- R1: On a start accepted while idle, the dividend and divisor are latched. Changes on the operand inputs after that edge have no effect on the result of that operation.
- R2: busy_o is high from the cycle after an accepted start through the done cycle, and low otherwise.
- R3: For a nonzero divisor, quotient_o equals dividend/divisor, remainder_o equals dividend mod divisor, and div_zero_o is 0.
- R4: For a nonzero divisor, done_o rises min(Q, W)+3 clock edges after the start edge, where Q is the quotient. When Q equals W, both engines finish together and the subtraction result is taken.
- R5: When a result is captured, both engines are cleared, so a following operation starts clean and gives a correct result even after a long losing run.
- R6: For a zero divisor, done_o rises 1 edge after the start edge with div_zero_o = 1, an all-ones quotient and a remainder equal to the dividend.
- R7: done_o is high for exactly one cycle, and the block is idle (busy_o low) in the next cycle.
- R8: A start_i pulse while busy_o is high is ignored. The running result and its timing are unchanged, and no second operation follows.
- R9: quotient_o, remainder_o and div_zero_o change only on the edge that raises done_o, and they hold their values until the next completion.
- R10: After reset, busy_o, done_o, div_zero_o, quotient_o and remainder_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only when idle |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | W | Registered quotient |
| remainder_o | output | W | Registered remainder |
| div_zero_o | output | 1 | Divisor was zero |

## Verification
Completion is due 1 edge after the start edge for a zero divisor, and min(Q, W)+3 edges after it otherwise. This makes the latency itself the observable evidence of which engine won. Each scenario task counts clock edges from the start edge and samples on the falling edge in the middle of each cycle until done_o appears. It then compares the edge count, the quotient, the remainder and the flag against values computed from the operands. The cycle after done is sampled as well, to confirm the single-cycle pulse and the return to idle. Operand inputs are scrambled, and stray start pulses are injected mid-run, without shifting the expected edge.

// File: rtl/race_div_pkg.sv
package race_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RUN,
    ST_FIN
  } ctl_state_e;
endpackage

// File: rtl/sub_div_engine.sv
// Repeated-subtraction divider: one subtraction per cycle, latency tracks the quotient.
module sub_div_engine #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic         active_q, done_q;
  logic [W-1:0] quo_q, rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      quo_q    <= '0;
      rem_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      quo_q    <= '0;
      rem_q    <= dividend_i;
    end else if (active_q) begin
      if (rem_q >= divisor_i) begin
        rem_q <= rem_q - divisor_i;
        quo_q <= quo_q + 1'b1;
      end else begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R3: a finished subtraction run leaves a remainder below the divisor
  p_sub_rem_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (rem_q < divisor_i));
  p_sub_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && active_q));
endmodule

// File: rtl/nrd_engine.sv
// Non-restoring divider: W shift/add-or-subtract steps, then one sign correction step.
module nrd_engine #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int PW = W + 2;
  localparam int CW = $clog2(W + 1);

  logic          active_q, done_q;
  logic [PW-1:0] part_q;
  logic [W-1:0]  acc_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] part_sh, part_nx, div_ext;

  assign div_ext = {2'b00, divisor_i};
  assign part_sh = {part_q[PW-2:0], acc_q[W-1]};
  // sign of the partial remainder chooses add or subtract
  assign part_nx = part_q[PW-1] ? (part_sh + div_ext) : (part_sh - div_ext);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      part_q   <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      done_q   <= 1'b0;
      part_q   <= '0;
      acc_q    <= dividend_i;
      cnt_q    <= CW'(W);
    end else if (active_q) begin
      if (cnt_q != '0) begin
        part_q <= part_nx;
        acc_q  <= {acc_q[W-2:0], ~part_nx[PW-1]};
        cnt_q  <= cnt_q - 1'b1;
      end else begin
        if (part_q[PW-1]) part_q <= part_q + div_ext;
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = acc_q;
  assign rem_o  = part_q[W-1:0];

  // R3: corrected remainder is non-negative and below the divisor
  p_nrd_rem_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!part_q[PW-1] && (part_q < div_ext)));
  // R4: completion only after all W steps
  p_nrd_steps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == '0));
endmodule

// File: rtl/race_div.sv
module race_div
  import race_div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         div_zero_o
);
  ctl_state_e   state_q;
  logic [W-1:0] op_a_q, op_b_q;
  logic [W-1:0] quo_q, rem_q;
  logic         dz_q;

  logic         eng_start, eng_clr, b_zero;
  logic         sub_done, nrd_done;
  logic [W-1:0] sub_quo, sub_rem, nrd_quo, nrd_rem;
  logic [W-1:0] sel_quo, sel_rem;

  assign b_zero    = (op_b_q == '0);
  assign eng_start = (state_q == ST_LOAD) && !b_zero;
  assign eng_clr   = (state_q == ST_RUN) && (sub_done || nrd_done);

  sub_div_engine #(.W(W)) u_sub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (eng_clr),
    .start_i    (eng_start),
    .dividend_i (op_a_q),
    .divisor_i  (op_b_q),
    .done_o     (sub_done),
    .quo_o      (sub_quo),
    .rem_o      (sub_rem)
  );

  nrd_engine #(.W(W)) u_nrd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (eng_clr),
    .start_i    (eng_start),
    .dividend_i (op_a_q),
    .divisor_i  (op_b_q),
    .done_o     (nrd_done),
    .quo_o      (nrd_quo),
    .rem_o      (nrd_rem)
  );

  // subtraction engine has priority on a tie
  always_comb begin
    if (sub_done) begin
      sel_quo = sub_quo;
      sel_rem = sub_rem;
    end else begin
      sel_quo = nrd_quo;
      sel_rem = nrd_rem;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_a_q  <= '0;
      op_b_q  <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dz_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_a_q  <= dividend_i;
          op_b_q  <= divisor_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (b_zero) begin
          quo_q   <= '1;
          rem_q   <= op_a_q;
          dz_q    <= 1'b1;
          state_q <= ST_FIN;
        end else begin
          state_q <= ST_RUN;
        end
        ST_RUN: if (sub_done || nrd_done) begin
          quo_q   <= sel_quo;
          rem_q   <= sel_rem;
          dz_q    <= 1'b0;
          state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign div_zero_o  = dz_q;

  p_busy_at_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R3: a tie must not produce disagreeing engine results
  p_tie_agree_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_done && nrd_done) |-> (sub_quo == nrd_quo && sub_rem == nrd_rem));
  p_engines_aborted_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!sub_done && !nrd_done));
  p_zero_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && b_zero) |=> (done_o && div_zero_o));
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(op_a_q) && $stable(op_b_q)));
  p_result_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));
endmodule

// File: tb/race_div_bench.sv
module race_div_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int OP_LIMIT = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, dz;
  logic [W-1:0] quo, rem;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  race_div #(.W(W)) u_race_div (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .busy_o      (busy),
    .done_o      (done),
    .quotient_o  (quo),
    .remainder_o (rem),
    .div_zero_o  (dz)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_lat(input int a, input int b);
    int q;
    if (b == 0) return 1;
    q = a / b;
    return ((q < W) ? q : W) + 3;
  endfunction

  // One operation. poke: inject a start with other operands mid-run (R8).
  task automatic run_div(input int a, input int b, input bit poke);
    int n = 0;
    bit busy_gap = 1'b0;
    int eq  = (b == 0) ? ((1 << W) - 1) : a / b;
    int er  = (b == 0) ? a : a % b;
    int el  = exp_lat(a, b);
    @(negedge clk);
    dividend = W'(a);
    divisor  = W'(b);
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start    = 1'b0;
    dividend = ~W'(a);           // R1: scramble after capture
    divisor  = W'(b) ^ W'(8'h5A);
    chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
    do begin
      if (poke && n == 1) start = 1'b1;
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (!busy) busy_gap = 1'b1;
    end while (!done && n < OP_LIMIT);
    chk(done == 1'b1, "R4", "done seen", int'(done), 1);
    chk(n == el, (b == 0) ? "R6" : "R4", "latency", n, el);
    chk(int'(quo) == eq, (b == 0) ? "R6" : "R3", "quotient", int'(quo), eq);
    chk(int'(rem) == er, (b == 0) ? "R6" : "R1", "remainder", int'(rem), er);
    chk(dz == (b == 0), (b == 0) ? "R6" : "R3", "div_zero", int'(dz), int'(b == 0));
    chk(!busy_gap, "R2", "busy held until done", int'(busy_gap), 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, poke ? "R8" : "R7", "idle after done",
        int'({done, busy}), 0);
    // R9: result holds while idle with operand inputs moving
    dividend = 8'h33;
    divisor  = 8'h07;
    repeat (2) @(negedge clk);
    chk(int'(quo) == eq && int'(rem) == er, "R9", "result held",
        int'(quo), eq);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0 && done == 0 && dz == 0, "R10", "reset flags",
        int'({busy, done, dz}), 0);
    chk(quo == 0 && rem == 0, "R10", "reset data", int'(quo), 0);
  endtask

  task automatic t_fast_paths();
    run_div(20, 7, 1'b0);   // R4 sub engine wins, Q=2
    run_div(0, 5, 1'b0);    // R4 Q=0
    run_div(7, 9, 1'b0);    // R3 dividend below divisor
    run_div(255, 255, 1'b0);
  endtask

  task automatic t_slow_paths();
    run_div(100, 7, 1'b0);  // R4 non-restoring engine wins
    run_div(255, 1, 1'b0);  // R5 long losing run, then next op below
    run_div(13, 4, 1'b0);   // R5 clean restart
    run_div(64, 8, 1'b0);   // R4 tie Q=W
    run_div(72, 8, 1'b0);   // Q=9
  endtask

  task automatic t_zero();
    run_div(200, 0, 1'b0);  // R6
    run_div(0, 0, 1'b0);    // R6
  endtask

  task automatic t_busy_start();
    run_div(250, 3, 1'b1);  // R8
    run_div(9, 2, 1'b1);    // R8
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 40; i++) begin
      run_div((i * 37 + 11) % 256, (i * 13 + 1) % 64, 1'b0);  // R3
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fast_paths();
    t_slow_paths();
    t_zero();
    t_busy_start();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule